// File: doc/BRIEF.md
# Split-Instruction Test Access Port

This block is the device side of an IEEE 1149.1 test port. It follows TCK, TMS and TDI, and it drives TDO together with an enable. Its 16-bit instruction register is not one opcode. The top four bits are a device-state command, which goes out to the debug logic of the chip. The lower twelve bits are an address that picks the data register placed between TDI and TDO.

Inside the block are the sixteen-state controller, the instruction register, a 32-bit identification register and a one-bit bypass path. A data register outside the block attaches through the address output, the capture, shift and update strobes, a claim input and a serial return input. When no register claims an address, that address behaves as a one-bit bypass.

Top module: `jtag_split_tap`

## Requirements
- R1: TMS and TDI are taken on the rising edge of TCK. TDO changes only on the falling edge of TCK, so a rising edge in Shift-DR leaves TDO unchanged until the next falling edge.
- R2: `tdo_oe` rises on the falling edge after the controller enters Shift-DR or Shift-IR. It is low in every other state, and TDO is high impedance while it is low.
- R3: Test-Logic-Reset, or `trst_n` low, sets the instruction to address 0x004 with command 0000. `dev_state` then reads 0000 and `dr_addr` reads 0x004, and a following data scan returns the identification value.
- R4: Capture-IR loads the instruction shift register with 0x0001, so bits 1:0 are 01 and all upper bits are zero. The first 16 bits out of an instruction scan are therefore 0x0001.
- R5: Both scans move least significant bit first. No bit moves on entry to a Shift state. One bit moves on every rising edge taken in the Shift state, including the edge that leaves it.
- R6: Address 0x004 (instruction bits 11:0) selects a 32-bit register that captures 0x10000243.
- R7: Address 0xFFF selects a one-bit bypass register that captures 0. An n-bit scan of value d therefore returns (d << 1) masked to n bits.
- R8: Any address other than 0x004 that `ext_sel` does not claim behaves as bypass. This includes 0x000, 0x002 and 0x123.
- R9: On Update-IR, `dev_state` loads instruction bits 15:12 when they are one of 0000 normal, 0001 halt, 0010 system reset, 0100 core suspend or 1111 normal. Any other code leaves `dev_state` unchanged.
- R10: `dr_addr` changes only on the edge that leaves Update-IR or an edge taken in Test-Logic-Reset.
- R11: `dr_capture`, `dr_shift` and `dr_update` are high in Capture-DR, Shift-DR and Update-DR respectively. While `ext_sel` is high, Shift-DR output comes from `ext_tdo`.
- R12: Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test-logic reset, active low |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial data in |
| ext_sel | input | 1 | An external register claims the current address |
| ext_tdo | input | 1 | Serial output of the claiming external register |
| tdo | output | 1 | Serial data out, high impedance when not enabled |
| tdo_oe | output | 1 | TDO drive enable |
| dev_state | output | 4 | Last valid device-state command |
| dr_addr | output | 12 | Address of the selected data register |
| dr_capture | output | 1 | Capture-DR strobe |
| dr_shift | output | 1 | Shift-DR strobe |
| dr_update | output | 1 | Update-DR strobe |

## Verification
The case that needs care is the exit edge of a Shift state, where the last data bit moves on the same rising edge that carries the controller into Exit1. Every scan the bench drives ends this way: the final bit is presented with TMS high. The bench judges the result by comparing the full word that comes back against the expected identification or bypass value, and the top bit of that word is the one that moves on the exit edge. A second coincidence is the Update-IR edge, which sets a new address and may keep the old command. The bench provokes it with a reserved command together with a new address, then checks that `dr_addr` moves while `dev_state` holds.

// File: rtl/jtag_split_pkg.sv
package jtag_split_pkg;

  typedef enum logic [3:0] {
    ST_TLR    = 4'hF, ST_RTI    = 4'hC,
    ST_SEL_DR = 4'h7, ST_CAP_DR = 4'h6, ST_SH_DR  = 4'h2, ST_EX1_DR = 4'h1,
    ST_PAU_DR = 4'h3, ST_EX2_DR = 4'h0, ST_UPD_DR = 4'h5,
    ST_SEL_IR = 4'h4, ST_CAP_IR = 4'hE, ST_SH_IR  = 4'hA, ST_EX1_IR = 4'h9,
    ST_PAU_IR = 4'hB, ST_EX2_IR = 4'h8, ST_UPD_IR = 4'hD
  } tap_state_e;

  // Successor of a controller state for a given TMS level.
  function automatic tap_state_e tap_next(tap_state_e s, logic m);
    case (s)
      ST_TLR:    return m ? ST_TLR    : ST_RTI;
      ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: return m ? ST_SEL_DR : ST_RTI;
      default:   return ST_TLR;
    endcase
  endfunction

  // True for the device-state commands that are acted upon.
  function automatic logic ctl_code_ok(logic [3:0] c);
    return (c == 4'b0000) || (c == 4'b0001) || (c == 4'b0010) ||
           (c == 4'b0100) || (c == 4'b1111);
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_split_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state_q
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= ST_TLR;
    else         state_q <= tap_next(state_q, tms);
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_split_pkg::*;
#(
  parameter int IR_W      = 16,
  parameter int CTL_W     = 4,
  parameter int ADDR_W    = IR_W - CTL_W,
  parameter logic [IR_W-1:0] RESET_IR = 16'h0004
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  tap_state_e        state_q,
  output logic              ir_so,
  output logic [IR_W-1:0]   ir_shift,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CTL_W-1:0]  ctl_q
);

  localparam logic [IR_W-1:0] CAPTURE_PAT = IR_W'(2'b01);
  localparam logic [CTL_W-1:0] RESET_CTL  = RESET_IR[IR_W-1 -: CTL_W];

  logic [CTL_W-1:0] new_ctl;
  assign new_ctl = ir_shift[IR_W-1 -: CTL_W];

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_shift <= '0;
      addr_q   <= RESET_IR[ADDR_W-1:0];
      ctl_q    <= RESET_CTL;
    end else begin
      case (state_q)
        ST_TLR: begin
          addr_q <= RESET_IR[ADDR_W-1:0];
          ctl_q  <= RESET_CTL;
        end
        ST_CAP_IR: ir_shift <= CAPTURE_PAT;
        ST_SH_IR:  ir_shift <= {tdi, ir_shift[IR_W-1:1]};
        ST_UPD_IR: begin
          addr_q <= ir_shift[ADDR_W-1:0];
          if (ctl_code_ok(new_ctl)) ctl_q <= new_ctl;
        end
        default: ;
      endcase
    end
  end

  assign ir_so = ir_shift[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import jtag_split_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ID_W   = 32,
  parameter logic [ID_W-1:0]   ID_VALUE = 32'h10000243,
  parameter logic [ADDR_W-1:0] ID_ADDR  = 12'h004
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  tap_state_e        state_q,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ext_sel,
  input  logic              ext_tdo,
  output logic              dr_so
);

  logic [ID_W-1:0] id_sr;
  logic            byp_q;
  logic            id_sel;

  assign id_sel = (addr == ID_ADDR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sr <= '0;
      byp_q <= 1'b0;
    end else begin
      case (state_q)
        ST_CAP_DR: begin
          if (id_sel) id_sr <= ID_VALUE;
          byp_q <= 1'b0;
        end
        ST_SH_DR: begin
          if (id_sel) id_sr <= {tdi, id_sr[ID_W-1:1]};
          byp_q <= tdi;
        end
        default: ;
      endcase
    end
  end

  assign dr_so = ext_sel ? ext_tdo : (id_sel ? id_sr[0] : byp_q);

endmodule

// File: rtl/jtag_split_tap.sv
module jtag_split_tap
  import jtag_split_pkg::*;
#(
  parameter int IR_W  = 16,
  parameter int CTL_W = 4,
  parameter int ID_W  = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h10000243,
  parameter logic [IR_W-CTL_W-1:0] ID_ADDR = 12'h004,
  localparam int ADDR_W = IR_W - CTL_W
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic              ext_sel,
  input  logic              ext_tdo,
  output logic              tdo,
  output logic              tdo_oe,
  output logic [CTL_W-1:0]  dev_state,
  output logic [ADDR_W-1:0] dr_addr,
  output logic              dr_capture,
  output logic              dr_shift,
  output logic              dr_update
);

  localparam logic [IR_W-1:0] RESET_IR = {{CTL_W{1'b0}}, ID_ADDR};

  tap_state_e      state_q;
  logic            ir_so;
  logic            dr_so;
  logic [IR_W-1:0] ir_shift;
  logic            in_shift;
  logic            oe_q;
  logic            tdo_q;

  tap_fsm u_fsm (
    .tck     (tck),
    .trst_n  (trst_n),
    .tms     (tms),
    .state_q (state_q)
  );

  tap_ir #(
    .IR_W     (IR_W),
    .CTL_W    (CTL_W),
    .ADDR_W   (ADDR_W),
    .RESET_IR (RESET_IR)
  ) u_ir (
    .tck      (tck),
    .trst_n   (trst_n),
    .tdi      (tdi),
    .state_q  (state_q),
    .ir_so    (ir_so),
    .ir_shift (ir_shift),
    .addr_q   (dr_addr),
    .ctl_q    (dev_state)
  );

  tap_dr #(
    .ADDR_W   (ADDR_W),
    .ID_W     (ID_W),
    .ID_VALUE (ID_VALUE),
    .ID_ADDR  (ID_ADDR)
  ) u_dr (
    .tck     (tck),
    .trst_n  (trst_n),
    .tdi     (tdi),
    .state_q (state_q),
    .addr    (dr_addr),
    .ext_sel (ext_sel),
    .ext_tdo (ext_tdo),
    .dr_so   (dr_so)
  );

  assign in_shift = (state_q == ST_SH_DR) || (state_q == ST_SH_IR);

  // Output stage runs on the falling edge of TCK.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      oe_q  <= 1'b0;
      tdo_q <= 1'b0;
    end else begin
      oe_q  <= in_shift;
      tdo_q <= (state_q == ST_SH_IR) ? ir_so : dr_so;
    end
  end

  assign tdo        = oe_q ? tdo_q : 1'bz;
  assign tdo_oe     = oe_q;
  assign dr_capture = (state_q == ST_CAP_DR);
  assign dr_shift   = (state_q == ST_SH_DR);
  assign dr_update  = (state_q == ST_UPD_DR);

endmodule

// File: rtl/jtag_split_tap_chk.sv
module jtag_split_tap_chk
  import jtag_split_pkg::*;
#(
  parameter int IR_W   = 16,
  parameter int CTL_W  = 4,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 12'h004
) (
  input logic              tck,
  input logic              trst_n,
  input logic              tms,
  input tap_state_e        state_q,
  input logic [IR_W-1:0]   ir_shift,
  input logic [CTL_W-1:0]  dev_state,
  input logic [ADDR_W-1:0] dr_addr,
  input logic              dr_capture,
  input logic              dr_update,
  input logic              tdo_oe
);

  logic [2:0] hi_run;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     hi_run <= '0;
    else if (!tms)   hi_run <= '0;
    else if (hi_run != 3'd7) hi_run <= hi_run + 3'd1;
  end

  // R12
  tlr_reach_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (hi_run >= 3'd5) |-> (state_q == ST_TLR));

  // R2
  oe_window_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == ((state_q == ST_SH_DR) || (state_q == ST_SH_IR)));

  // R3
  tlr_defaults_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_TLR) |=> (dev_state == '0 && dr_addr == RESET_ADDR));

  // R9
  reserved_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_UPD_IR && !ctl_code_ok(ir_shift[IR_W-1 -: CTL_W]))
      |=> $stable(dev_state));

  // R9
  valid_load_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_UPD_IR && ctl_code_ok(ir_shift[IR_W-1 -: CTL_W]))
      |=> (dev_state == $past(ir_shift[IR_W-1 -: CTL_W])));

  // R10
  addr_change_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(dr_addr) |-> ($past(state_q) == ST_UPD_IR || $past(state_q) == ST_TLR));

  // R11
  capture_entry_chk: assert property (@(posedge tck) disable iff (!trst_n)
    dr_capture |-> ($past(state_q) == ST_SEL_DR));

  // R11
  update_entry_chk: assert property (@(posedge tck) disable iff (!trst_n)
    dr_update |-> ($past(state_q) == ST_EX1_DR || $past(state_q) == ST_EX2_DR));

endmodule

bind jtag_split_tap jtag_split_tap_chk #(
  .IR_W       (IR_W),
  .CTL_W      (CTL_W),
  .ADDR_W     (ADDR_W),
  .RESET_ADDR (ID_ADDR)
) u_chk (
  .tck        (tck),
  .trst_n     (trst_n),
  .tms        (tms),
  .state_q    (state_q),
  .ir_shift   (ir_shift),
  .dev_state  (dev_state),
  .dr_addr    (dr_addr),
  .dr_capture (dr_capture),
  .dr_update  (dr_update),
  .tdo_oe     (tdo_oe)
);

// File: tb/tb_jtag_split_tap.sv
module tb_jtag_split_tap;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic ext_sel = 1'b0, ext_tdo = 1'b0;
  wire        tdo, tdo_oe, dr_capture, dr_shift, dr_update;
  wire [3:0]  dev_state;
  wire [11:0] dr_addr;

  jtag_split_tap dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .ext_sel(ext_sel), .ext_tdo(ext_tdo),
    .tdo(tdo), .tdo_oe(tdo_oe), .dev_state(dev_state), .dr_addr(dr_addr),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update)
  );

  always #4 tck = ~tck;   // 125 MHz

  localparam logic [31:0] IDV = 32'h10000243;

  int   checks = 0, fails = 0;
  bit   done = 0;
  logic last_tdo;

  typedef struct { string tag; logic [31:0] val; } exp_t;
  exp_t        exp_q[$];
  logic [31:0] act_q[$];
  event        got_ev;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Scoreboard monitor: pairs each result with its expectation.
  initial begin
    exp_t        e;
    logic [31:0] a;
    forever begin
      @(got_ev);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        a = act_q.pop_front();
        chk(e.tag, a, e.val);
      end
    end
  end

  // Inputs change after the falling edge; TDO is read just before the rising edge.
  task automatic step(input logic m, input logic d);
    @(negedge tck);
    #1; tms = m; tdi = d;
    #2; last_tdo = tdo;
  endtask

  task automatic shift_bits(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      dout[i] = last_tdo;
    end
  endtask

  task automatic scan_ir(input logic [15:0] v, input string tag);
    logic [31:0] r;
    exp_q.push_back('{tag, 32'h0000_0001});
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    shift_bits(16, {16'h0, v}, r);
    step(1, 0); step(0, 0); step(0, 0);
    act_q.push_back(r);
    ->got_ev;
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, input string tag,
                         input logic [31:0] exp);
    logic [31:0] r;
    exp_q.push_back('{tag, exp});
    step(1, 0); step(0, 0); step(0, 0);
    shift_bits(n, din, r);
    step(1, 0); step(0, 0); step(0, 0);
    act_q.push_back(r);
    ->got_ev;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge tck);
    // R3 reset state
    chk("R3 reset dev_state", 32'(dev_state), 32'h0);
    chk("R3 reset dr_addr", 32'(dr_addr), 32'h004);
    chk("R2 reset tdo_oe", 32'(tdo_oe), 32'h0);
    #1 trst_n = 1'b1;
    step(0, 0); step(0, 0);

    // R6 R5 identification after reset
    scan_dr(32, 32'h0, "R6 R5 id readout", IDV);

    // R4 capture pattern; R9 halt command; R7 bypass address
    scan_ir(16'h1FFF, "R4 ir capture");
    chk("R9 halt dev_state", 32'(dev_state), 32'h1);
    chk("R10 addr after update", 32'(dr_addr), 32'hFFF);
    scan_dr(8, 32'hA5, "R7 bypass 8 bits", 32'h4A);

    // R11 R2 R1 walk through a bypass data scan edge by edge
    step(1, 0); step(0, 0);
    @(posedge tck); #1;
    chk("R11 capture strobe", 32'(dr_capture), 32'h1);
    step(0, 0);
    @(posedge tck); #1;
    chk("R11 shift strobe", 32'(dr_shift), 32'h1);
    chk("R2 oe low before falling edge", 32'(tdo_oe), 32'h0);
    step(0, 1);
    chk("R2 oe high in shift", 32'(tdo_oe), 32'h1);
    chk("R7 captured zero", 32'(last_tdo), 32'h0);
    @(posedge tck); #1;
    chk("R1 tdo holds at rising edge", 32'(tdo), 32'h0);
    step(1, 0);
    chk("R1 R5 tdo moves at falling edge", 32'(last_tdo), 32'h1);
    step(1, 0);
    chk("R2 oe low in exit1", 32'(tdo_oe), 32'h0);
    @(posedge tck); #1;
    chk("R11 update strobe", 32'(dr_update), 32'h1);
    step(0, 0); step(0, 0);

    // R9 reserved command keeps state; R10 R8 new address is bypass
    scan_ir(16'h3123, "R4 ir capture reserved");
    chk("R9 reserved holds", 32'(dev_state), 32'h1);
    chk("R10 addr 123", 32'(dr_addr), 32'h123);
    scan_dr(8, 32'h3C, "R8 unimplemented bypass", 32'h78);

    scan_ir(16'h2000, "R4 ir capture sysreset");
    chk("R9 system reset code", 32'(dev_state), 32'h2);
    scan_dr(4, 32'hF, "R8 address 000 bypass", 32'hE);

    scan_ir(16'h4004, "R4 ir capture suspend");
    chk("R9 suspend code", 32'(dev_state), 32'h4);
    scan_dr(32, 32'hFFFF_FFFF, "R6 id with ones in", IDV);

    // R11 external register claim; R9 code 1111
    scan_ir(16'hF0A0, "R4 ir capture ext");
    chk("R9 code 1111", 32'(dev_state), 32'hF);
    ext_sel = 1'b1; ext_tdo = 1'b1;
    scan_dr(4, 32'h0, "R11 external serial out", 32'hF);
    ext_sel = 1'b0; ext_tdo = 1'b0;

    // R12 R3 five TMS-high edges from Shift-DR
    step(1, 0); step(0, 0); step(0, 0);
    repeat (5) step(1, 0);
    step(0, 0); step(0, 0);
    chk("R12 R3 tlr dev_state", 32'(dev_state), 32'h0);
    chk("R12 R3 tlr dr_addr", 32'(dr_addr), 32'h004);
    scan_dr(32, 32'h0, "R3 id after tlr", IDV);

    // R3 asynchronous reset pin
    scan_ir(16'h1FFF, "R4 ir capture before trst");
    @(negedge tck); #1 trst_n = 1'b0;
    #2;
    chk("R3 trst dev_state", 32'(dev_state), 32'h0);
    chk("R3 trst dr_addr", 32'(dr_addr), 32'h004);
    @(negedge tck); #1 trst_n = 1'b1; tms = 1'b0;
    step(0, 0);
    scan_dr(32, 32'h0, "R3 id after trst", IDV);

    repeat (2) @(negedge tck);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule